// File: doc/BRIEF.md
# Banked Register Window Translator

This block turns a wide register address into an access through a narrow window. A host issues one request at a time on a small register bus. The request carries a port index, a 5-bit device number, a 16-bit register number, a direction and 16 bits of write data. The translator joins the device and register numbers into a 21-bit flat address. The upper part of that address becomes a bank number and the low byte becomes a slot offset inside a 256-slot window. Each accepted request then runs two target transactions in a fixed order. The first writes the bank number into the bank register at the top slot of the window. The second reads or writes the chosen slot.

The window words are 32 bits wide, but only their low half carries register data. Two kinds of request are refused before anything reaches the target: a request to a port whose window is marked reserved, and a request to the top slot, because that slot holds the bank register. A target model with banked storage is included behind the translator so that the path can be exercised end to end. That model holds a small number of banks and slots per port and flags any access outside them.

Top module: `banked_window_xlat`

## Requirements
- R1: The flat address is {device[4:0], register[15:0]} (21 bits). The bank number is that address shifted right by 8 (13 bits) and the slot is its low 8 bits, so register bits [15:8] and the device number together pick the bank.
- R2: An accepted request with no decode error writes the bank number to window slot 0xFF first and then accesses its slot. The response arrives 4 cycles after the accepting edge (counted in response-visible clock periods) with code 0 (ok) and rsp_err low.
- R3: A request whose slot is 0xFF on a non-reserved port issues no target transaction. It is answered in the cycle right after acceptance with code 2 and rsp_err high.
- R4: A request to a port set in RESERVED_MASK, or to a port index at or above NPORT, is answered in the cycle right after acceptance with code 1 and rsp_err high, whatever its slot. No target transaction is issued.
- R5: If the target refuses the bank write, the data access is skipped. The host gets code 3 with rsp_err high, 2 cycles after acceptance.
- R6: A write stores the 16-bit data in the low half of a 32-bit window word. A read returns only the low 16 bits of the addressed word. A read that completes with an error, and any non-read response, returns 0 on rsp_rdata.
- R7: req_ready is high only while no request is in flight. rsp_valid is a single-cycle strobe, and req_ready stays low in that strobe cycle, so a request held valid across it is taken exactly once, afterwards.
- R8: After reset req_ready is 1, rsp_valid is 0 and the target model's storage and bank registers read 0.
- R9: The target model keeps a separate bank register and separate storage for each port. It refuses a bank number of 2^MODEL_BANK_BITS or more. It refuses a data access to a slot of 2^MODEL_SLOT_BITS or more, and the host sees that refusal as code 4 with rsp_err high, 4 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Translator can accept a request |
| req_port | input | PORT_W | Port (window) index |
| req_dev | input | 5 | Device number |
| req_regaddr | input | 16 | Register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_err | output | 1 | Response carries an error |
| rsp_code | output | 3 | 0 ok, 1 no device, 2 bank slot addressed, 3 bank write refused, 4 data access refused |
| rsp_rdata | output | 16 | Read data, low half of the window word |

## Verification
Two events can meet in one cycle. The first is the response strobe for the current request, while the host is already holding the next request valid. The bench provokes this by leaving req_valid high with new fields during the strobe. It then judges that req_ready is low in that cycle, that the first response carries the first request's data, and that the second request is taken once and answered on its own. The second meeting is two rejection causes in one request: a reserved port addressed at slot 0xFF. There the no-device code must win and the response must arrive with no target traffic. Around these two cases, a sweep over every stored bank and slot of the open ports checks the data path arithmetically. It also checks the response latency of each outcome.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

    localparam int DEV_W   = 5;
    localparam int REG_W   = 16;
    localparam int FLAT_W  = DEV_W + REG_W;
    localparam int SLOT_W  = 8;
    localparam int BANK_W  = FLAT_W - SLOT_W;
    localparam int WORD_W  = 32;
    localparam int DATA_W  = 16;

    localparam logic [SLOT_W-1:0] BANK_SLOT = {SLOT_W{1'b1}};

    typedef enum logic [2:0] {
        RC_OK       = 3'd0,
        RC_NODEV    = 3'd1,
        RC_BADSLOT  = 3'd2,
        RC_BANKFAIL = 3'd3,
        RC_DATAFAIL = 3'd4
    } rcode_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [SLOT_W-1:0] slot;
    } waddr_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BANK,
        S_BANK_WT,
        S_DATA,
        S_DATA_WT,
        S_RESP
    } xstate_e;

    function automatic waddr_t split_addr(input logic [DEV_W-1:0] dev,
                                          input logic [REG_W-1:0] regaddr);
        logic [FLAT_W-1:0] flat;
        waddr_t            w;
        flat   = {dev, regaddr};
        w.bank = flat[FLAT_W-1:SLOT_W];
        w.slot = flat[SLOT_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/bwx_decode.sv
module bwx_decode
    import bwx_pkg::*;
#(
    parameter int                NPORT         = 4,
    parameter int                PORT_W        = 2,
    parameter logic [NPORT-1:0]  RESERVED_MASK = '0
) (
    input  logic [PORT_W-1:0] port,
    input  logic [DEV_W-1:0]  dev,
    input  logic [REG_W-1:0]  regaddr,
    output waddr_t            waddr,
    output rcode_e            code
);
    logic port_closed;

    always_comb begin
        port_closed = 1'b1;
        for (int i = 0; i < NPORT; i++) begin
            if (int'(port) == i) port_closed = RESERVED_MASK[i];
        end
    end

    always_comb begin
        waddr = split_addr(dev, regaddr);
        if (port_closed)                 code = RC_NODEV;
        else if (waddr.slot == BANK_SLOT) code = RC_BADSLOT;
        else                              code = RC_OK;
    end
endmodule

// File: rtl/bwx_seq.sv
module bwx_seq
    import bwx_pkg::*;
#(
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PORT_W-1:0] req_port,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  waddr_t            dec_addr,
    input  rcode_e            dec_code,
    output logic              tgt_req,
    output logic              tgt_we,
    output logic [PORT_W-1:0] tgt_port,
    output logic [SLOT_W-1:0] tgt_addr,
    output logic [WORD_W-1:0] tgt_wdata,
    input  logic              tgt_ack,
    input  logic              tgt_err,
    input  logic [WORD_W-1:0] tgt_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output rcode_e            rsp_code,
    output logic [DATA_W-1:0] rsp_rdata
);
    xstate_e           state;
    logic [PORT_W-1:0] cur_port;
    waddr_t            cur_addr;
    logic              cur_we;
    logic [DATA_W-1:0] cur_wdata;
    rcode_e            code_q;
    logic [DATA_W-1:0] rdata_q;

    assign req_ready = (state == S_IDLE);
    assign rsp_valid = (state == S_RESP);
    assign rsp_code  = code_q;
    assign rsp_err   = (code_q != RC_OK);
    assign rsp_rdata = rdata_q;
    assign tgt_port  = cur_port;

    always_comb begin
        tgt_req   = 1'b0;
        tgt_we    = 1'b0;
        tgt_addr  = '0;
        tgt_wdata = '0;
        case (state)
            S_BANK: begin
                tgt_req   = 1'b1;
                tgt_we    = 1'b1;
                tgt_addr  = BANK_SLOT;
                tgt_wdata = WORD_W'(cur_addr.bank);
            end
            S_DATA: begin
                tgt_req   = 1'b1;
                tgt_we    = cur_we;
                tgt_addr  = cur_addr.slot;
                tgt_wdata = WORD_W'(cur_wdata);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur_port  <= '0;
            cur_addr  <= '0;
            cur_we    <= 1'b0;
            cur_wdata <= '0;
            code_q    <= RC_OK;
            rdata_q   <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_port  <= req_port;
                        cur_addr  <= dec_addr;
                        cur_we    <= req_write;
                        cur_wdata <= req_wdata;
                        rdata_q   <= '0;
                        code_q    <= dec_code;
                        state     <= (dec_code == RC_OK) ? S_BANK : S_RESP;
                    end
                end
                S_BANK: state <= S_BANK_WT;
                S_BANK_WT: begin
                    if (tgt_ack) begin
                        if (tgt_err) begin
                            code_q <= RC_BANKFAIL;
                            state  <= S_RESP;
                        end else begin
                            state  <= S_DATA;
                        end
                    end
                end
                S_DATA: state <= S_DATA_WT;
                S_DATA_WT: begin
                    if (tgt_ack) begin
                        code_q  <= tgt_err ? RC_DATAFAIL : RC_OK;
                        rdata_q <= (!cur_we && !tgt_err) ? tgt_rdata[DATA_W-1:0] : '0;
                        state   <= S_RESP;
                    end
                end
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bwx_target.sv
module bwx_target
    import bwx_pkg::*;
#(
    parameter int NPORT           = 4,
    parameter int PORT_W          = 2,
    parameter int MODEL_BANK_BITS = 2,
    parameter int MODEL_SLOT_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [PORT_W-1:0] port,
    input  logic [SLOT_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              ack,
    output logic              err,
    output logic [WORD_W-1:0] rdata
);
    localparam int NB = 1 << MODEL_BANK_BITS;
    localparam int NS = 1 << MODEL_SLOT_BITS;

    logic [DATA_W-1:0] mem    [NPORT][NB][NS];
    logic [BANK_W-1:0] bank_q [NPORT];

    logic              port_ok;
    logic [BANK_W-1:0] sel_bank;
    logic [DATA_W-1:0] sel_word;

    always_comb begin
        port_ok  = 1'b0;
        sel_bank = '0;
        sel_word = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(port) == p) begin
                port_ok  = 1'b1;
                sel_bank = bank_q[p];
                sel_word = mem[p][sel_bank[MODEL_BANK_BITS-1:0]][addr[MODEL_SLOT_BITS-1:0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
            for (int p = 0; p < NPORT; p++) begin
                bank_q[p] <= '0;
                for (int b = 0; b < NB; b++)
                    for (int s = 0; s < NS; s++)
                        mem[p][b][s] <= '0;
            end
        end else begin
            ack   <= req;
            err   <= 1'b0;
            rdata <= '0;
            if (req) begin
                if (!port_ok) begin
                    err <= 1'b1;
                end else if (addr == BANK_SLOT) begin
                    if (we) begin
                        if (wdata >= WORD_W'(NB)) err <= 1'b1;
                        else                      bank_q[port] <= wdata[BANK_W-1:0];
                    end else begin
                        rdata <= WORD_W'(sel_bank);
                    end
                end else if (32'(addr) >= 32'(NS) || 32'(sel_bank) >= 32'(NB)) begin
                    err <= 1'b1;
                end else if (we) begin
                    mem[port][sel_bank[MODEL_BANK_BITS-1:0]][addr[MODEL_SLOT_BITS-1:0]]
                        <= wdata[DATA_W-1:0];
                end else begin
                    rdata <= {~sel_word, sel_word};
                end
            end
        end
    end
endmodule

// File: rtl/banked_window_xlat.sv
module banked_window_xlat
    import bwx_pkg::*;
#(
    parameter int               NPORT           = 4,
    parameter logic [NPORT-1:0] RESERVED_MASK   = 4'b1000,
    parameter int               MODEL_BANK_BITS = 2,
    parameter int               MODEL_SLOT_BITS = 4,
    localparam int              PORT_W          = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PORT_W-1:0] req_port,
    input  logic [4:0]        req_dev,
    input  logic [15:0]       req_regaddr,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [2:0]        rsp_code,
    output logic [15:0]       rsp_rdata
);
    waddr_t            dec_addr;
    rcode_e            dec_code;
    rcode_e            code_e;
    logic              tgt_req;
    logic              tgt_we;
    logic [PORT_W-1:0] tgt_port;
    logic [SLOT_W-1:0] tgt_addr;
    logic [WORD_W-1:0] tgt_wdata;
    logic              tgt_ack;
    logic              tgt_err;
    logic [WORD_W-1:0] tgt_rdata;

    bwx_decode #(
        .NPORT(NPORT), .PORT_W(PORT_W), .RESERVED_MASK(RESERVED_MASK)
    ) u_decode (
        .port(req_port), .dev(req_dev), .regaddr(req_regaddr),
        .waddr(dec_addr), .code(dec_code)
    );

    bwx_seq #(.PORT_W(PORT_W)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_write(req_write), .req_wdata(req_wdata),
        .dec_addr(dec_addr), .dec_code(dec_code),
        .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_port(tgt_port),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_ack(tgt_ack), .tgt_err(tgt_err), .tgt_rdata(tgt_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_code(code_e), .rsp_rdata(rsp_rdata)
    );

    assign rsp_code = code_e;

    bwx_target #(
        .NPORT(NPORT), .PORT_W(PORT_W),
        .MODEL_BANK_BITS(MODEL_BANK_BITS), .MODEL_SLOT_BITS(MODEL_SLOT_BITS)
    ) u_target (
        .clk(clk), .rst(rst),
        .req(tgt_req), .we(tgt_we), .port(tgt_port), .addr(tgt_addr),
        .wdata(tgt_wdata), .ack(tgt_ack), .err(tgt_err), .rdata(tgt_rdata)
    );
endmodule

// File: rtl/bwx_checker.sv
module bwx_checker #(
    parameter int               NPORT         = 4,
    parameter int               PORT_W        = 2,
    parameter logic [NPORT-1:0] RESERVED_MASK = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [PORT_W-1:0] req_port,
    input logic [15:0]       req_regaddr,
    input logic              rsp_valid,
    input logic [2:0]        rsp_code,
    input logic              tgt_req,
    input logic              tgt_we,
    input logic [PORT_W-1:0] tgt_port,
    input logic [7:0]        tgt_addr,
    input logic              tgt_ack,
    input logic              tgt_err
);
    logic last_bank;
    logic bank_ok;
    logic req_closed;
    logic tgt_closed;

    always_comb begin
        req_closed = 1'b1;
        tgt_closed = 1'b1;
        for (int i = 0; i < NPORT; i++) begin
            if (int'(req_port) == i) req_closed = RESERVED_MASK[i];
            if (int'(tgt_port) == i) tgt_closed = RESERVED_MASK[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_bank <= 1'b0;
            bank_ok   <= 1'b0;
        end else begin
            if (tgt_req) last_bank <= (tgt_addr == 8'hFF);
            if (rsp_valid)
                bank_ok <= 1'b0;
            else if (tgt_ack && last_bank && !tgt_err)
                bank_ok <= 1'b1;
        end
    end

    p_bank_slot_written_r1: assert property (@(posedge clk) disable iff (rst)
        (tgt_req && tgt_addr == 8'hFF) |-> tgt_we);

    p_bank_before_data_r2: assert property (@(posedge clk) disable iff (rst)
        (tgt_req && tgt_addr != 8'hFF) |-> bank_ok);

    p_badslot_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_closed && req_regaddr[7:0] == 8'hFF)
        |=> (rsp_valid && rsp_code == 3'd2 && !tgt_req));

    p_nodev_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_closed)
        |=> (rsp_valid && rsp_code == 3'd1 && !tgt_req));

    p_closed_port_silent_r4: assert property (@(posedge clk) disable iff (rst)
        tgt_req |-> !tgt_closed);

    p_bank_fail_skips_r5: assert property (@(posedge clk) disable iff (rst)
        (tgt_ack && tgt_err && last_bank)
        |=> (rsp_valid && rsp_code == 3'd3 && !tgt_req));

    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (tgt_req || rsp_valid) |-> !req_ready);

    p_rsp_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind banked_window_xlat bwx_checker #(
    .NPORT(NPORT), .PORT_W(PORT_W), .RESERVED_MASK(RESERVED_MASK)
) u_bwx_checker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_regaddr(req_regaddr),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_port(tgt_port),
    .tgt_addr(tgt_addr), .tgt_ack(tgt_ack), .tgt_err(tgt_err)
);

// File: tb/test_banked_window_xlat.sv
module test_banked_window_xlat;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT      = 4;
    localparam int NB         = 4;
    localparam int NS         = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_port = '0;
    logic [4:0]  req_dev = '0;
    logic [15:0] req_regaddr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [2:0]  rsp_code;
    logic [15:0] rsp_rdata;

    int n_cmp = 0;
    int n_mis = 0;
    int got_lat;
    logic [2:0]  got_code;
    logic        got_err;
    logic [15:0] got_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_window_xlat #(
        .NPORT(NPORT), .RESERVED_MASK(4'b1000),
        .MODEL_BANK_BITS(2), .MODEL_SLOT_BITS(4)
    ) i_banked_window_xlat (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_dev(req_dev), .req_regaddr(req_regaddr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input int p, input int b, input int s);
        return 16'((p * 16'h1111) ^ (b << 12) ^ (s * 16'h0107) ^ 16'hA5C3);
    endfunction

    task automatic wait_rsp();
        got_lat = 0;
        while (!rsp_valid && got_lat < 20) begin
            @(negedge clk);
            got_lat++;
        end
        got_code = rsp_code;
        got_err  = rsp_err;
        got_data = rsp_rdata;
    endtask

    task automatic do_req(input int p, input logic [4:0] d, input logic [15:0] r,
                          input bit w, input logic [15:0] wd);
        req_port    = 2'(p);
        req_dev     = d;
        req_regaddr = r;
        req_write   = w;
        req_wdata   = wd;
        req_valid   = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp();
    endtask

    task automatic expect_rsp(input string tag, input int code, input int lat,
                              input logic [15:0] data);
        check(got_code == 3'(code) && got_err == (code != 0),
              {tag, " code"}, int'(got_code), code);
        check(got_lat == lat, {tag, " latency"}, got_lat, lat);
        check(got_data == data, {tag, " data"}, int'(got_data), int'(data));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R8 reset outputs",
              {req_ready, rsp_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);

        // R8: storage reads zero after reset
        do_req(1, 5'd0, 16'h0203, 1'b0, 16'h0);
        expect_rsp("R8 cleared storage", 0, 4, 16'h0000);

        // R1 R2 R6: exhaustive write sweep over open ports, stored banks and slots
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < NB; b++)
                for (int s = 0; s < NS; s++) begin
                    do_req(p, 5'd0, 16'((b << 8) | s), 1'b1, pattern(p, b, s));
                    expect_rsp("R2 write", 0, 4, 16'h0000);
                end
        // R1 R6 R9: read back, each port and bank separate
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < NB; b++)
                for (int s = 0; s < NS; s++) begin
                    do_req(p, 5'd0, 16'((b << 8) | s), 1'b0, 16'h0);
                    expect_rsp("R6 R9 readback", 0, 4, pattern(p, b, s));
                end

        // R3: slot 0xFF refused, nothing stored
        do_req(0, 5'd0, 16'h01FF, 1'b1, 16'hDEAD);
        expect_rsp("R3 bank slot", 2, 0, 16'h0000);
        do_req(0, 5'd0, 16'h0105, 1'b0, 16'h0);
        expect_rsp("R3 no side effect", 0, 4, pattern(0, 1, 5));

        // R4: reserved port, even at slot 0xFF (no-device wins)
        do_req(3, 5'd0, 16'h0002, 1'b0, 16'h0);
        expect_rsp("R4 reserved port", 1, 0, 16'h0000);
        do_req(3, 5'd0, 16'h00FF, 1'b1, 16'h1234);
        expect_rsp("R4 reserved port and bank slot", 1, 0, 16'h0000);

        // R1 R5: device bits enter the bank number -> bank 0x100 refused
        do_req(0, 5'd1, 16'h0005, 1'b1, 16'hBEEF);
        expect_rsp("R5 bank refused via device", 3, 2, 16'h0000);
        // R5: bank 4 just past the model range
        do_req(2, 5'd0, 16'h0405, 1'b0, 16'h0);
        expect_rsp("R5 bank boundary", 3, 2, 16'h0000);
        do_req(0, 5'd0, 16'h0005, 1'b0, 16'h0);
        expect_rsp("R5 no side effect", 0, 4, pattern(0, 0, 5));

        // R9: slot past stored range -> data refused
        do_req(1, 5'd0, 16'h0320, 1'b0, 16'h0);
        expect_rsp("R9 slot refused", 4, 4, 16'h0000);
        do_req(1, 5'd0, 16'h01FE, 1'b1, 16'h0);
        expect_rsp("R9 slot 0xFE refused", 4, 4, 16'h0000);

        // R7: request held valid across the response strobe
        req_port = 2'd2; req_dev = 5'd0; req_regaddr = 16'h030F;
        req_write = 1'b1; req_wdata = 16'h5A5A; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_write = 1'b0; req_wdata = 16'h0;
        wait_rsp();
        check(req_ready == 1'b0, "R7 ready low during strobe", req_ready, 0);
        expect_rsp("R7 first of pair", 0, 4, 16'h0000);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R7 strobe single cycle", rsp_valid, 0);
        check(req_ready == 1'b1, "R7 ready back", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp();
        expect_rsp("R7 second of pair", 0, 4, 16'h5A5A);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R7 taken once", rsp_valid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_mis++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule